// File: doc/BRIEF.md
# Display control register bank

This block is the software-facing register file of a framebuffer scanout engine. A simple 32-bit bus with a valid, a write strobe, a byte address and write data reaches a small set of words. The words hold the framebuffer base address, the active-area mode (height and width), the pixel format, the scanout enable, a vsync status bit, and two event counters. The configuration leaves the block as plain wires to the timing and fetch logic. That logic sends back one-cycle pulses: one for vsync, one for each active pixel that was starved of data, and one for each active pixel that was fetched successfully.

The format word accepts one encoding only and ignores every other write. A zero width or height is exported as 1, so the downstream address generator never sees an empty axis. The counters stop at all-ones. Any write to a counter clears it, whatever the data.

Top module: `disp_ctrl_regs`

## Requirements
- R1: After reset, base reads 0, mode reads 0 (exported width 1 and height 1), format reads 0x34325258, enable reads 0, and both counters read 0.
- R2: A write to byte address 0x00 stores all 32 bits as the base. The same value reads back and appears on cfg_base_o in the cycle after the write.
- R3: The word at 0x04 holds height in bits [31:16] and width in bits [15:0]. It reads back exactly as written. cfg_width_o and cfg_height_o export each field, but a field equal to 0 is exported as 1.
- R4: The format word at 0x08 is updated only by a write of 0x34325258 (the ASCII bytes 'X','R','2','4' in little-endian order). A write of any other value leaves it unchanged.
- R5: Bit 0 of the word at 0x0C is the scanout enable and drives cfg_enable_o. Bits [31:1] read as 0.
- R6: A read of 0x10 returns vsync_pulse_i, as sampled in the request cycle, in bit 0 and zero in bits [31:1]. Writes to 0x10 have no effect.
- R7: The underflow counter (0x14) adds 1 in each cycle where underflow_inc_i is high. The fetched counter (0x18) adds 1 in each cycle where fetched_inc_i is high. Each counter responds only to its own pulse.
- R8: Any write to 0x14 or 0x18 clears that counter to 0, whatever the write data. When a clear and an increment fall in the same cycle, the clear wins.
- R9: A counter that holds all-ones (CNT_W bits) stays at all-ones on further increments.
- R10: A read of any address other than the seven words (including unaligned addresses) returns 0. A write to such an address changes no register.
- R11: Each read request yields rsp_valid_o high for exactly one cycle, in the cycle after the request, with rsp_rdata_o valid in that cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |
| cfg_base_o | output | 32 | Framebuffer base address |
| cfg_width_o | output | 16 | Active width, zero clamped to 1 |
| cfg_height_o | output | 16 | Active height, zero clamped to 1 |
| cfg_format_o | output | 32 | Pixel format code |
| cfg_enable_o | output | 1 | Scanout enable |
| vsync_pulse_i | input | 1 | One-cycle vsync pulse from timing logic |
| underflow_inc_i | input | 1 | Starved active pixel pulse |
| fetched_inc_i | input | 1 | Fetched active pixel pulse |

## Verification
A corrupted configuration word reaches the cfg outputs in the cycle after the offending write and shows on the bus at the next read. An address-decode fault shows up in the same way, as a register that moves on the wrong offset or a stray nonzero read. A counter fault stays hidden until the counter is read. The bench therefore reads each counter after controlled pulse bursts that land exactly on a clear, on saturation and on the other counter's pulse, so an off-by-one or a wrap appears in a single read. Response timing is held to one cycle, so a missing, doubled or write-triggered response is caught at once.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;
  localparam logic [31:0] FMT_XR24 = 32'h3432_5258;

  localparam int unsigned OFS_BASE   = 'h00;
  localparam int unsigned OFS_MODE   = 'h04;
  localparam int unsigned OFS_FMT    = 'h08;
  localparam int unsigned OFS_EN     = 'h0C;
  localparam int unsigned OFS_VSYNC  = 'h10;
  localparam int unsigned OFS_UFLOW  = 'h14;
  localparam int unsigned OFS_FETCH  = 'h18;

  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned CNT_UFLOW = 0;
  localparam int unsigned CNT_FETCH = 1;

  function automatic logic [15:0] clamp_dim(input logic [15:0] v);
    return (v == 16'd0) ? 16'd1 : v;
  endfunction
endpackage

// File: rtl/disp_sat_counter.sv
module disp_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;   // clear wins over increment
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/disp_cfg_regs.sv
module disp_cfg_regs
  import disp_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_base_i,
  input  logic        we_mode_i,
  input  logic        we_fmt_i,
  input  logic        we_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] base_o,
  output logic [31:0] mode_o,
  output logic [31:0] fmt_o,
  output logic        en_o,
  output logic [15:0] width_o,
  output logic [15:0] height_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      mode_o <= '0;
      fmt_o  <= FMT_XR24;
      en_o   <= 1'b0;
    end else begin
      if (we_base_i) base_o <= wdata_i;
      if (we_mode_i) mode_o <= wdata_i;
      if (we_fmt_i && wdata_i == FMT_XR24) fmt_o <= wdata_i;
      if (we_en_i) en_o <= wdata_i[0];
    end
  end

  assign width_o  = clamp_dim(mode_o[15:0]);
  assign height_o = clamp_dim(mode_o[31:16]);
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_regs_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned CNT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_rdata_o,
  output logic [31:0]   cfg_base_o,
  output logic [15:0]   cfg_width_o,
  output logic [15:0]   cfg_height_o,
  output logic [31:0]   cfg_format_o,
  output logic          cfg_enable_o,
  input  logic          vsync_pulse_i,
  input  logic          underflow_inc_i,
  input  logic          fetched_inc_i
);
  logic wr, rd;
  logic hit_base, hit_mode, hit_fmt, hit_en, hit_vs, hit_uf, hit_fe;
  logic [31:0] mode_raw;
  logic [NUM_CNT-1:0] cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt_val [NUM_CNT];
  logic [31:0] cnt_ext [NUM_CNT];
  logic [31:0] rd_mux;

  assign wr = req_valid_i &  req_write_i;
  assign rd = req_valid_i & ~req_write_i;

  assign hit_base = req_addr_i == AW'(OFS_BASE);
  assign hit_mode = req_addr_i == AW'(OFS_MODE);
  assign hit_fmt  = req_addr_i == AW'(OFS_FMT);
  assign hit_en   = req_addr_i == AW'(OFS_EN);
  assign hit_vs   = req_addr_i == AW'(OFS_VSYNC);
  assign hit_uf   = req_addr_i == AW'(OFS_UFLOW);
  assign hit_fe   = req_addr_i == AW'(OFS_FETCH);

  disp_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_base_i (wr & hit_base),
    .we_mode_i (wr & hit_mode),
    .we_fmt_i  (wr & hit_fmt),
    .we_en_i   (wr & hit_en),
    .wdata_i   (req_wdata_i),
    .base_o    (cfg_base_o),
    .mode_o    (mode_raw),
    .fmt_o     (cfg_format_o),
    .en_o      (cfg_enable_o),
    .width_o   (cfg_width_o),
    .height_o  (cfg_height_o)
  );

  assign cnt_clr[CNT_UFLOW] = wr & hit_uf;
  assign cnt_clr[CNT_FETCH] = wr & hit_fe;
  assign cnt_inc[CNT_UFLOW] = underflow_inc_i;
  assign cnt_inc[CNT_FETCH] = fetched_inc_i;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    disp_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr[i]),
      .inc_i  (cnt_inc[i]),
      .cnt_o  (cnt_val[i])
    );
    always_comb begin
      cnt_ext[i] = '0;
      cnt_ext[i][CNT_W-1:0] = cnt_val[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit_base: rd_mux = cfg_base_o;
      hit_mode: rd_mux = mode_raw;
      hit_fmt:  rd_mux = cfg_format_o;
      hit_en:   rd_mux = {31'd0, cfg_enable_o};
      hit_vs:   rd_mux = {31'd0, vsync_pulse_i};
      hit_uf:   rd_mux = cnt_ext[CNT_UFLOW];
      hit_fe:   rd_mux = cnt_ext[CNT_FETCH];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/disp_ctrl_regs_chk.sv
module disp_ctrl_regs_chk #(
  parameter int unsigned AW    = 8,
  parameter int unsigned CNT_W = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic [31:0]   req_wdata_i,
  input logic          rsp_valid_o,
  input logic [15:0]   cfg_width_o,
  input logic [15:0]   cfg_height_o,
  input logic [31:0]   cfg_format_o,
  input logic          cfg_enable_o,
  input logic          underflow_inc_i,
  input logic [CNT_W-1:0] uf_cnt
);
  localparam logic [CNT_W-1:0] MAX = '1;
  logic wr_uf, wr_fmt, wr_en;
  assign wr_uf  = req_valid_i && req_write_i && req_addr_i == AW'('h14);
  assign wr_fmt = req_valid_i && req_write_i && req_addr_i == AW'('h08);
  assign wr_en  = req_valid_i && req_write_i && req_addr_i == AW'('h0C);

  AST_DIM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_width_o != 16'd0 && cfg_height_o != 16'd0); // R3
  AST_FMT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_fmt && req_wdata_i == 32'h3432_5258) |=> $stable(cfg_format_o)); // R4
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg_enable_o)); // R5
  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_uf && underflow_inc_i && uf_cnt != MAX) |=> uf_cnt == $past(uf_cnt) + 1'b1); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_uf |=> uf_cnt == '0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_uf && uf_cnt == MAX) |=> uf_cnt == MAX); // R9
  AST_RSP_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o); // R11
  AST_RSP_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o); // R11
endmodule

bind disp_ctrl_regs disp_ctrl_regs_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_write_i     (req_write_i),
  .req_addr_i      (req_addr_i),
  .req_wdata_i     (req_wdata_i),
  .rsp_valid_o     (rsp_valid_o),
  .cfg_width_o     (cfg_width_o),
  .cfg_height_o    (cfg_height_o),
  .cfg_format_o    (cfg_format_o),
  .cfg_enable_o    (cfg_enable_o),
  .underflow_inc_i (underflow_inc_i),
  .uf_cnt          (cnt_val[0])
);

// File: tb/disp_ctrl_regs_bench.sv
module disp_ctrl_regs_bench;
  localparam int unsigned AW = 8;
  localparam int unsigned CNT_W = 4;
  localparam logic [31:0] XR24 = 32'h3432_5258;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 0, req_write = 0, vsync = 0, uf_inc = 0, fe_inc = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata, base;
  logic [15:0] width, height;
  logic [31:0] fmt;
  logic en;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  disp_ctrl_regs #(.AW(AW), .CNT_W(CNT_W)) u_disp_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .cfg_base_o(base), .cfg_width_o(width), .cfg_height_o(height),
    .cfg_format_o(fmt), .cfg_enable_o(en),
    .vsync_pulse_i(vsync), .underflow_inc_i(uf_inc), .fetched_inc_i(fe_inc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0; vsync = 0;
  endtask

  task automatic pulses(input bit u, input bit f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); uf_inc = u; fe_inc = f;
    end
    @(negedge clk); uf_inc = 0; fe_inc = 0;
  endtask

  // monitor: pops one expectation per response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && rsp_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11: actual=unexpected response expected=none");
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset values
    check("R1 width", {16'd0, width}, 32'd1);
    check("R1 height", {16'd0, height}, 32'd1);
    check("R1 enable", {31'd0, en}, 32'd0);
    rd('h00, 32'd0, "R1 base");
    rd('h04, 32'd0, "R1 mode");
    rd('h08, XR24, "R1 format");
    rd('h0C, 32'd0, "R1 enable rd");
    rd('h14, 32'd0, "R1 uflow");
    rd('h18, 32'd0, "R1 fetch");
    // R2
    wr('h00, 32'h8000_1000);
    check("R2 cfg_base", base, 32'h8000_1000);
    rd('h00, 32'h8000_1000, "R2 base rd");
    // R3
    wr('h04, 32'h0500_02D0);
    check("R3 width", {16'd0, width}, 32'h2D0);
    check("R3 height", {16'd0, height}, 32'h500);
    rd('h04, 32'h0500_02D0, "R3 mode rd");
    wr('h04, 32'h0000_0040);
    check("R3 height clamp", {16'd0, height}, 32'd1);
    check("R3 width kept", {16'd0, width}, 32'h40);
    rd('h04, 32'h0000_0040, "R3 raw rd");
    wr('h04, 32'h0020_0000);
    check("R3 width clamp", {16'd0, width}, 32'd1);
    // R4
    wr('h08, 32'h3432_4241);
    check("R4 fmt out", fmt, XR24);
    rd('h08, XR24, "R4 fmt rd");
    wr('h08, 32'h0);
    rd('h08, XR24, "R4 fmt zero");
    wr('h08, XR24);
    rd('h08, XR24, "R4 fmt legal");
    // R5
    wr('h0C, 32'hFFFF_FFFF);
    check("R5 enable on", {31'd0, en}, 32'd1);
    rd('h0C, 32'd1, "R5 enable rd");
    wr('h0C, 32'hFFFF_FFFE);
    check("R5 enable off", {31'd0, en}, 32'd0);
    // R6
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 'h10; vsync = 1;
    exp_q.push_back(32'd1); tag_q.push_back("R6 vsync hi");
    @(negedge clk); req_valid = 0; vsync = 0;
    rd('h10, 32'd0, "R6 vsync lo");
    wr('h10, 32'hFFFF_FFFF);
    rd('h10, 32'd0, "R6 vsync write ignored");
    // R7
    pulses(1, 0, 3);
    rd('h14, 32'd3, "R7 uflow count");
    rd('h18, 32'd0, "R7 fetch isolated");
    pulses(0, 1, 5);
    rd('h18, 32'd5, "R7 fetch count");
    rd('h14, 32'd3, "R7 uflow isolated");
    // R8
    wr('h18, 32'h0);
    rd('h18, 32'd0, "R8 fetch cleared");
    rd('h14, 32'd3, "R8 uflow untouched");
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 'h14; req_wdata = 32'h1234; uf_inc = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; uf_inc = 0;
    rd('h14, 32'd0, "R8 clear wins");
    // R9
    pulses(1, 1, 20);
    rd('h14, 32'd15, "R9 uflow sat");
    rd('h18, 32'd15, "R9 fetch sat");
    // R10
    wr('h1C, 32'hDEAD_BEEF);
    wr('h01, 32'hDEAD_BEEF);
    wr('h05, 32'hDEAD_BEEF);
    rd('h1C, 32'd0, "R10 unmapped rd");
    rd('h01, 32'd0, "R10 unaligned rd");
    rd('h00, 32'h8000_1000, "R10 base intact");
    rd('h04, 32'h0020_0000, "R10 mode intact");
    rd('hFC, 32'd0, "R10 high rd");
    // R11: writes give no response (monitor flags any)
    wr('h00, 32'h1);
    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule